// File: doc/BRIEF.md
# Four-Lane Polyphase CIC Decimator

This block is the first rate-reduction stage behind a single-bit sigma-delta modulator, such as a third-order one sampling at 12.288 MHz. It lowers the sample rate by 128 with a fifth-order cascaded integrator-comb response, so a 12.288 MHz bit stream becomes a 96 kHz stream of wide words. Later compensation and half-band stages take these words.

The block does not step its integrators once per modulator bit. It takes four modulator bits on every clock, so the core runs at a quarter of the modulator rate (3.072 MHz nominal). The response (1 + z^-1 + ... + z^-127)^5 is split into two factors. The first factor, (1 + z^-1 + z^-2 + z^-3)^5, is evaluated once per four-bit group as a weighted sum of the last 16 bits. The second factor is a fifth-order CIC that decimates by 32 at the core rate. Its combs step only on the decimation strobe, with a differential delay of one. The output word is two's complement and uses modular arithmetic throughout. A one-cycle valid pulse marks each new word.

Top module: `cic_quad_decim`

## Requirements
- R1: A bit value 1 counts as +1 and a bit value 0 counts as -1. A steady all-ones input settles at +128^5 (2^35) and a steady all-zeros input settles at -128^5.
- R2: After reset is released, `out_valid` pulses high for exactly one cycle after every 32nd rising clock edge. The first pulse follows the 32nd edge, and pulses are never closer than 32 cycles apart.
- R3: Samples are numbered so that group g (the bits presented before rising edge g+1 after release, starting at g = 0) holds samples 4g to 4g+3. The p-th output word (p = 1, 2, ...) then equals the sum of h[k]·x[128p−25−k] for k = 0 to 635. Here h is the coefficient list of (1 + z^-1 + ... + z^-127)^5 and x is ±1 as given in R1. This holds from the seventh word after reset onward.
- R4: `out_data` is 37 bits wide, two's complement (2 + 5·log2 128). Full scale ±2^35 is represented without wrapping, and a word never leaves that range.
- R5: While `rst_n` is low, `out_valid` is 0 and `out_data` is 0. A reset applied in mid-run restarts the 32-cycle phase count and clears all history.
- R6: `out_data` holds its value in every cycle in which `out_valid` is low.
- R7: Within `mod_bits`, bit 0 is the earliest sample of the group and bit 3 the latest. Asymmetric patterns such as 4'b0001 are filtered according to this order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, one quarter of the modulator rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mod_bits | input | 4 | Four modulator bits per clock, bit 0 earliest |
| out_data | output | 37 | Decimated two's-complement word |
| out_valid | output | 1 | One-cycle strobe marking a new word |

## Verification
The bench builds the block with its default parameters: order 5, decimation 128 and four lanes. These give a 37-bit word and a new output every 32 clocks, so several hundred words fit in a few thousand cycles. With these values the bench can drive both full-scale DC extremes, exactly +2^35 and −2^35, where a word one bit narrower would wrap. It can also compare every word after the fill against a direct 636-tap convolution of the bits it drove. Alternating and single-lane patterns expose any error in lane order or tap alignment.

// File: rtl/cic_quad_pkg.sv
package cic_quad_pkg;

  localparam int unsigned MAX_TAPS = 256;

  // Coefficient k of (1 + x + ... + x^(lanes-1))^order, computed by repeated box convolution.
  function automatic int unsigned lane_coef(input int unsigned k,
                                            input int unsigned order,
                                            input int unsigned lanes);
    int unsigned cur [MAX_TAPS];
    int unsigned nxt [MAX_TAPS];
    for (int unsigned j = 0; j < MAX_TAPS; j++) cur[j] = 0;
    cur[0] = 1;
    for (int unsigned s = 0; s < order; s++) begin
      for (int unsigned j = 0; j < MAX_TAPS; j++) begin
        nxt[j] = 0;
        for (int unsigned i = 0; i < lanes; i++) begin
          if (i <= j) nxt[j] = nxt[j] + cur[j - i];
        end
      end
      for (int unsigned j = 0; j < MAX_TAPS; j++) cur[j] = nxt[j];
    end
    return (k < MAX_TAPS) ? cur[k] : 0;
  endfunction

endpackage

// File: rtl/cic_phase_fir.sv
module cic_phase_fir #(
  parameter int LANES = 4,
  parameter int ORDER = 5,
  parameter int FW    = 2 + ORDER * $clog2(LANES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LANES-1:0]     bits_i,
  output logic signed [FW-1:0] sum_o
);
  import cic_quad_pkg::*;

  localparam int TAPS = ORDER * (LANES - 1) + 1;
  localparam int HGRP = (TAPS - 1 + LANES - 1) / LANES;
  localparam int HW   = LANES * HGRP;
  localparam int WIN  = LANES + HW;
  localparam int FULL = LANES ** ORDER;

  logic [HW-1:0]           hist_q, hist_n;
  logic [WIN-1:0]          seq;
  logic [FW-2:0]           term [WIN];
  logic [FW-2:0]           acc;
  logic signed [FW-1:0]    sum_n;

  assign seq = {bits_i, hist_q};

  // Bit b of the window lies WIN-1-b samples behind the newest one.
  for (genvar b = 0; b < WIN; b++) begin : g_tap
    localparam int          AGE = WIN - 1 - b;
    localparam int unsigned CK  = (AGE < TAPS) ? lane_coef(AGE, ORDER, LANES) : 0;
    assign term[b] = seq[b] ? (FW-1)'(CK) : '0;
  end

  always_comb begin
    acc = '0;
    for (int b = 0; b < WIN; b++) acc = acc + term[b];
    // sum of c*(2x-1) = 2*sum(c*x) - sum(c)
    sum_n  = $signed({acc, 1'b0}) - $signed(FW'(FULL));
    hist_n = seq[WIN-1 -: HW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      sum_o  <= '0;
    end else begin
      hist_q <= hist_n;
      sum_o  <= sum_n;
    end
  end

endmodule

// File: rtl/cic_integ_chain.sv
module cic_integ_chain #(
  parameter int STAGES = 5,
  parameter int IW     = 12,
  parameter int W      = 37
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic signed [IW-1:0] din,
  output logic signed [W-1:0]  dout
);
  logic signed [W-1:0] acc_q [STAGES];
  logic signed [W-1:0] acc_n [STAGES];
  logic signed [W-1:0] din_ext;

  assign din_ext = {{(W-IW){din[IW-1]}}, din};

  // Each stage adds the registered value of the stage before it; sums wrap modulo 2^W.
  always_comb begin
    acc_n[0] = acc_q[0] + din_ext;
    for (int i = 1; i < STAGES; i++) acc_n[i] = acc_q[i] + acc_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) acc_q[i] <= '0;
    end else begin
      for (int i = 0; i < STAGES; i++) acc_q[i] <= acc_n[i];
    end
  end

  assign dout = acc_q[STAGES-1];

endmodule

// File: rtl/cic_comb_chain.sv
module cic_comb_chain #(
  parameter int STAGES = 5,
  parameter int W      = 37
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step_en,
  input  logic signed [W-1:0] din,
  output logic signed [W-1:0] dout
);
  logic signed [W-1:0] dly_q [STAGES];
  logic signed [W-1:0] diff  [STAGES+1];

  always_comb begin
    diff[0] = din;
    for (int i = 0; i < STAGES; i++) diff[i+1] = diff[i] - dly_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) dly_q[i] <= '0;
      dout <= '0;
    end else if (step_en) begin
      for (int i = 0; i < STAGES; i++) dly_q[i] <= diff[i];
      dout <= diff[STAGES];
    end
  end

endmodule

// File: rtl/cic_quad_decim.sv
module cic_quad_decim #(
  parameter int ORDER = 5,
  parameter int DECIM = 128,
  parameter int LANES = 4,
  localparam int OW   = 2 + ORDER * $clog2(DECIM)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] mod_bits,
  output logic [OW-1:0]    out_data,
  output logic             out_valid
);
  localparam int SPAN = DECIM / LANES;
  localparam int FW   = 2 + ORDER * $clog2(LANES);
  localparam int CW   = $clog2(SPAN);

  logic signed [FW-1:0] fir_sum;
  logic signed [OW-1:0] integ_out;
  logic signed [OW-1:0] comb_out;
  logic [CW-1:0]        phase_q, phase_n;
  logic                 strobe;
  logic                 valid_n;

  cic_phase_fir #(.LANES(LANES), .ORDER(ORDER), .FW(FW)) u_fir (
    .clk    (clk),
    .rst_n  (rst_n),
    .bits_i (mod_bits),
    .sum_o  (fir_sum)
  );

  cic_integ_chain #(.STAGES(ORDER), .IW(FW), .W(OW)) u_integ (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (fir_sum),
    .dout  (integ_out)
  );

  always_comb begin
    strobe  = (phase_q == CW'(SPAN - 1));
    phase_n = strobe ? '0 : phase_q + 1'b1;
    valid_n = strobe;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= '0;
      out_valid <= 1'b0;
    end else begin
      phase_q   <= phase_n;
      out_valid <= valid_n;
    end
  end

  cic_comb_chain #(.STAGES(ORDER), .W(OW)) u_comb (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_en (strobe),
    .din     (integ_out),
    .dout    (comb_out)
  );

  assign out_data = comb_out;

endmodule

// File: rtl/cic_quad_decim_chk.sv
module cic_quad_decim_chk #(
  parameter int DECIM = 128,
  parameter int LANES = 4,
  parameter int OW    = 37
) (
  input logic          clk,
  input logic          rst_n,
  input logic [OW-1:0] out_data,
  input logic          out_valid
);
  localparam int SPAN = DECIM / LANES;
  localparam int GW   = $clog2(SPAN) + 2;

  logic signed [OW-1:0] lim_pos, lim_neg;
  logic [GW-1:0]        gap_q;

  assign lim_pos = OW'(1) <<< (OW - 2);
  assign lim_neg = -lim_pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         gap_q <= '0;
    else if (out_valid) gap_q <= GW'(1);
    else if (gap_q <= GW'(SPAN)) gap_q <= gap_q + 1'b1;
  end

  // R2
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R2
  valid_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> gap_q == GW'(SPAN));

  // R2
  gap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gap_q <= GW'(SPAN));

  // R6
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));

  // R4
  word_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($signed(out_data) <= lim_pos && $signed(out_data) >= lim_neg));

  // R5
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_clear_chk: assert (!out_valid && out_data == '0);
    end
  end

endmodule

bind cic_quad_decim cic_quad_decim_chk #(.DECIM(DECIM), .LANES(LANES), .OW(OW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .out_data  (out_data),
  .out_valid (out_valid)
);

// File: tb/sim_cic_quad_decim.sv
`timescale 1ns/1ps
module sim_cic_quad_decim;
  localparam int ORDER = 5;
  localparam int DECIM = 128;
  localparam int LANES = 4;
  localparam int SPAN  = DECIM / LANES;
  localparam int OW    = 2 + ORDER * $clog2(DECIM);
  localparam int TAPS  = ORDER * (DECIM - 1) + 1;
  localparam int BUFN  = 1024;
  localparam int LAT   = 25;
  localparam int WARM  = 7;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [LANES-1:0] mod_bits;
  logic [OW-1:0]    out_data;
  logic             out_valid;

  int     checks = 0;
  int     fails  = 0;
  bit     done   = 0;
  int     cyc    = 0;
  int     outs   = 0;
  longint held   = 0;
  longint h [TAPS];
  bit     sbuf [BUFN];

  cic_quad_decim #(.ORDER(ORDER), .DECIM(DECIM), .LANES(LANES)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .mod_bits  (mod_bits),
    .out_data  (out_data),
    .out_valid (out_valid)
  );

  always #2 clk = ~clk;

  function automatic longint wrap(input longint v);
    longint t;
    t = v <<< (64 - OW);
    return t >>> (64 - OW);
  endfunction

  // Direct convolution of the driven +/-1 samples with the full 636-tap response.
  function automatic longint ref_out(input int p);
    longint s = 0;
    int n0 = p * DECIM - LAT;
    for (int k = 0; k < TAPS; k++) begin
      if (sbuf[(n0 - k) % BUFN]) s = s + h[k];
      else                        s = s - h[k];
    end
    return s;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic put(input logic [LANES-1:0] g);
    for (int j = 0; j < LANES; j++) sbuf[(LANES * cyc + j) % BUFN] = g[j];
    mod_bits = g;
  endtask

  task automatic observe();
    longint act;
    act = longint'($signed(out_data));
    if (out_valid) begin
      outs++;
      check("R2 pulse position", longint'(cyc), longint'(outs * SPAN));
      if (outs >= WARM) check("R3 R7 filtered word", act, wrap(ref_out(outs)));
      held = act;
    end else begin
      if (cyc % SPAN == 0) check("R2 missing pulse", 0, 1);
      if (act !== held) check("R6 hold between pulses", act, held);
    end
  endtask

  function automatic logic [LANES-1:0] pick(input int mode);
    case (mode)
      0:       return '1;
      1:       return '0;
      3:       return 4'b0101;
      4:       return 4'b0001;
      default: return LANES'($urandom);
    endcase
  endfunction

  task automatic step(input logic [LANES-1:0] g);
    @(negedge clk);
    cyc++;
    observe();
    put(g);
  endtask

  task automatic run(input int mode, input int n);
    for (int i = 0; i < n; i++) step(pick(mode));
  endtask

  task automatic release_rst(input logic [LANES-1:0] g);
    @(negedge clk);
    rst_n = 1'b1;
    cyc   = 0;
    outs  = 0;
    held  = 0;
    put(g);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    longint tmp [TAPS];
    longint full;
    void'($urandom(32'd7));
    full = longint'(1) <<< (OW - 2);

    for (int k = 0; k < TAPS; k++) h[k] = 0;
    h[0] = 1;
    for (int s = 0; s < ORDER; s++) begin
      for (int k = 0; k < TAPS; k++) begin
        tmp[k] = 0;
        for (int i = 0; i < DECIM; i++) if (i <= k) tmp[k] = tmp[k] + h[k - i];
      end
      for (int k = 0; k < TAPS; k++) h[k] = tmp[k];
    end

    rst_n    = 1'b0;
    mod_bits = '0;
    repeat (3) @(negedge clk);
    check("R5 valid low in reset", longint'(out_valid), 0);
    check("R5 data zero in reset", longint'($signed(out_data)), 0);

    release_rst('1);
    run(0, 400);
    check("R1 all-ones DC level", held, full);
    check("R4 full scale keeps sign bit clear", longint'(out_data[OW-1]), 0);

    run(1, 400);
    check("R1 all-zeros DC level", held, -full);

    run(3, 300);
    check("R3 alternating input settles at zero", held, 0);

    run(4, 300);
    check("R7 single-lane pattern DC level", held, -(full / 2));

    run(2, 800);

    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R5 valid cleared by mid-run reset", longint'(out_valid), 0);
    check("R5 data cleared by mid-run reset", longint'($signed(out_data)), 0);

    release_rst(LANES'($urandom));
    run(2, 500);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule